// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

The block is one memory-to-memory copy channel. Software programs a source address, a destination address and a 32-bit control word. The control word sets the unit size, how each pointer steps, the unit count, the start condition, repeat behaviour and whether completion raises an interrupt. The copy starts in one of two ways. It can start as soon as the enable bit rises, or it can wait for one of seven trigger inputs. Each unit is moved as a read and then a write over a single bus master port. Every access is held for a number of cycles that depends on the address region and the unit size. While units are moving, the engine holds a stall request towards the processor.

A trigger code is reserved for feeding a FIFO consumer. In that mode each trigger moves a burst of at most `CHUNK` units (112 by default). Between bursts the engine parks and keeps its working pointers and its remaining count. When the last unit is done, the engine clears its own enable bit unless repeat is set, and it can raise a one-cycle interrupt.

The controller has five states:
- IDLE: disabled or finished.
- WAIT: armed and waiting for a trigger.
- READ: source access.
- WRITE: destination access.
- FINISH: one completion cycle.

Its transitions are:
- IDLE→READ: enable with the immediate code.
- IDLE→WAIT: enable with a trigger code.
- WAIT→READ: a matching trigger.
- READ→WRITE: the read completes.
- WRITE→READ: units remain in the burst.
- WRITE→WAIT: the burst cap is reached and units remain.
- WRITE→FINISH: the last unit is written.
- FINISH→WAIT: repeat is set with a trigger code.
- FINISH→IDLE: every other case.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset, `cpu_stall`, `irq`, `mem_req` and `mem_we` are low and `ctrl_rd` reads zero.
- R2: `cfg_wr_sel` selects the register written: 0 is source, 1 is destination, 2 is control. A control write that takes bit 31 from 0 to 1 copies both programmed addresses into the working pointers and latches the step modes, the unit size and the start code. A control write that finds bit 31 already set changes no working pointer.
- R3: Destination step is set by control bits 22:21. Code 0 increments, 1 decrements and 2 holds. Code 3 increments and also reloads the working destination from the programmed destination at every start.
- R4: Source step is set by control bits 24:23. Code 0 increments, 1 decrements and 2 holds. Code 3 behaves as increment.
- R5: Control bit 26 set gives 32-bit units that step by 4. Clear gives 16-bit units that step by 2, and the written data carries the low 16 bits of the read data with the upper half zero.
- R6: The unit count is control bits `CNT_W`-1:0. A count of zero means 2^`CNT_W` units.
- R7: Control bits 29:27 hold the start code. Code 0 starts at the enable edge. Code k (1 to 7) waits for `trig_in[k]` while bit 31 is set. A trigger that arrives while units are moving is ignored.
- R8: With code 7, one trigger moves at most `CHUNK` units. If units remain, the engine drops the stall, keeps bit 31 set, raises no interrupt and waits. The next trigger resumes from the same pointers and the same remaining count.
- R9: Each access lasts a number of cycles looked up from address bits 27:24 and the unit size. Regions 0x8 and 0x9 cost 6 cycles for halfwords and 12 for words. Region 0xA costs 10 for either size. Regions 0x2, 0x5 and 0x6 cost 2 for words. Every other case costs 1. With `mem_ready` held high, one unit takes the source cost plus the destination cost.
- R10: After the last unit, bit 31 is cleared unless repeat bit 25 is set. If bit 30 is set, `irq` is high for exactly one cycle.
- R11: `cpu_stall` is high exactly while a read or write access is in progress.
- R12: Each unit is one read followed by one write. An access keeps its request, address and direction until its wait count has run out and `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| cfg_wr_data | input | 32 | Register write data |
| ctrl_rd | output | 32 | Current control word |
| trig_in | input | 8 | Start triggers, bit k for start code k (bit 0 unused) |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus write enable |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_rdata | input | 32 | Bus read data |
| mem_ready | input | 1 | Bus ready |
| cpu_stall | output | 1 | Processor stall request |
| irq | output | 1 | Completion interrupt pulse |

## Verification
In FIFO-fed mode, a new trigger and the final write of a burst can fall in the same clock cycle. The bench provokes this by raising `trig_in[7]` during the write phase of the 112th unit, where the destination costs one cycle. It then drops the trigger at the next falling edge. The engine is correct if it parks in its waiting state: the stall stays low, exactly 112 writes have been made and bit 31 remains set, and only the later clean trigger moves the remaining 88 units.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_READ,
        S_WRITE,
        S_FINISH
    } dma_state_e;

    typedef enum logic [1:0] {
        STEP_INC    = 2'd0,
        STEP_DEC    = 2'd1,
        STEP_FIX    = 2'd2,
        STEP_INC_RL = 2'd3
    } step_e;

    localparam logic [2:0] START_NOW  = 3'd0;
    localparam logic [2:0] START_FIFO = 3'd7;
    localparam int         COST_W     = 4;

    // cycles one access takes, by address region and unit size
    function automatic logic [COST_W-1:0] access_cost(input logic [3:0] region,
                                                      input logic       word);
        logic [COST_W-1:0] c;
        case (region)
            4'h8, 4'h9:       c = word ? 4'd12 : 4'd6;
            4'hA:             c = 4'd10;
            4'h2, 4'h5, 4'h6: c = word ? 4'd2 : 4'd1;
            default:          c = 4'd1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 21,
    parameter int REM_W = CNT_W + 1
) (
    input  logic [31:0]      ctrl,
    output step_e            src_step,
    output step_e            dst_step,
    output logic             word,
    output logic             repeat_en,
    output logic             irq_en,
    output logic [2:0]       start_code,
    output logic [REM_W-1:0] unit_count
);
    localparam logic [REM_W-1:0] MAX_UNITS = REM_W'(1) << CNT_W;

    logic [CNT_W-1:0] raw_count;

    always_comb begin
        raw_count  = ctrl[CNT_W-1:0];
        dst_step   = step_e'(ctrl[22:21]);
        // reserved source code runs as a plain increment
        src_step   = (ctrl[24:23] == 2'd3) ? STEP_INC : step_e'(ctrl[24:23]);
        word       = ctrl[26];
        repeat_en  = ctrl[25];
        irq_en     = ctrl[30];
        start_code = ctrl[29:27];
        unit_count = (raw_count == '0) ? MAX_UNITS : REM_W'(raw_count);
    end
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  step_e             step,
    input  logic              word,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_next
);
    logic [ADDR_W-1:0] delta;

    always_comb begin
        delta = word ? ADDR_W'(4) : ADDR_W'(2);
        unique case (step)
            STEP_INC, STEP_INC_RL: ptr_next = ptr + delta;
            STEP_DEC:              ptr_next = ptr - delta;
            STEP_FIX:              ptr_next = ptr;
            default:               ptr_next = ptr;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (adv)
            ptr <= ptr_next;
    end
endmodule

// File: rtl/dma_wait_timer.sv
module dma_wait_timer
    import dma_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [3:0] region,
    input  logic       word,
    output logic       expired
);
    logic [COST_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= access_cost(region, word) - COST_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - COST_W'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
    import dma_chan_pkg::*;
#(
    parameter int CNT_W  = 21,
    parameter int CHUNK  = 112,
    parameter int TRIG_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    output logic [31:0]       ctrl_rd,
    input  logic [TRIG_N-1:0] trig_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              cpu_stall,
    output logic              irq
);
    localparam int               REM_W     = CNT_W + 1;
    localparam logic [REM_W-1:0] CHUNK_MAX = REM_W'(CHUNK);
    localparam logic [1:0]       SEL_SRC   = 2'd0;
    localparam logic [1:0]       SEL_DST   = 2'd1;
    localparam logic [1:0]       SEL_CTRL  = 2'd2;

    dma_state_e state_q, state_d;

    logic [31:0]      src_q, dst_q, ctrl_q, ctrl_view, data_q;
    logic [REM_W-1:0] rem_q, iter_q, rem_start, iter_start;
    logic             in_prog_q, word_q;
    step_e            smode_q, dmode_q;
    logic [2:0]       start_q;

    // decoded view of the control word being written or held
    step_e            dec_src, dec_dst;
    logic             dec_word, dec_rep, dec_irq;
    logic [2:0]       dec_start;
    logic [REM_W-1:0] dec_count;

    logic        ctrl_wr, en_rise, start_now, rd_done, unit_done;
    logic        cur_word, dst_load, t_load, t_word, t_expired;
    step_e       cur_dmode;
    logic [2:0]  cur_start;
    logic [31:0] start_src, src_ptr, src_next, dst_ptr, dst_next, t_addr;

    assign ctrl_wr   = cfg_wr_en && (cfg_wr_sel == SEL_CTRL);
    assign ctrl_view = ctrl_wr ? cfg_wr_data : ctrl_q;

    dma_ctrl_decode #(.CNT_W(CNT_W), .REM_W(REM_W)) u_decode (
        .ctrl       (ctrl_view),
        .src_step   (dec_src),
        .dst_step   (dec_dst),
        .word       (dec_word),
        .repeat_en  (dec_rep),
        .irq_en     (dec_irq),
        .start_code (dec_start),
        .unit_count (dec_count)
    );

    // start and handshake conditions
    always_comb begin
        en_rise   = ctrl_wr && !ctrl_q[31] && cfg_wr_data[31] &&
                    (state_q == S_IDLE || state_q == S_WAIT);
        cur_word  = en_rise ? dec_word  : word_q;
        cur_dmode = en_rise ? dec_dst   : dmode_q;
        cur_start = en_rise ? dec_start : start_q;
        start_src = en_rise ? src_q     : src_ptr;
        start_now = (en_rise && dec_start == START_NOW) ||
                    (!en_rise && state_q == S_WAIT && ctrl_q[31] && trig_in[start_q]);
        rd_done   = (state_q == S_READ)  && t_expired && mem_ready;
        unit_done = (state_q == S_WRITE) && t_expired && mem_ready;
        rem_start = (in_prog_q && !en_rise) ? rem_q : dec_count;
        iter_start = (cur_start == START_FIFO && rem_start > CHUNK_MAX) ? CHUNK_MAX : rem_start;
        dst_load  = en_rise || (start_now && cur_dmode == STEP_INC_RL);
    end

    // working pointers
    dma_ptr_unit #(.ADDR_W(32)) u_src_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (en_rise),
        .load_val (src_q),
        .adv      (unit_done),
        .step     (smode_q),
        .word     (word_q),
        .ptr      (src_ptr),
        .ptr_next (src_next)
    );

    dma_ptr_unit #(.ADDR_W(32)) u_dst_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dst_load),
        .load_val (dst_q),
        .adv      (unit_done),
        .step     (dmode_q),
        .word     (word_q),
        .ptr      (dst_ptr),
        .ptr_next (dst_next)
    );

    // access cost countdown
    always_comb begin
        t_load = start_now || rd_done || unit_done;
        t_word = cur_word;
        if (start_now)
            t_addr = start_src;
        else if (rd_done)
            t_addr = dst_ptr;
        else
            t_addr = src_next;
    end

    dma_wait_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (t_load),
        .region  (t_addr[27:24]),
        .word    (t_word),
        .expired (t_expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_now)
                    state_d = S_READ;
                else if (en_rise)
                    state_d = S_WAIT;
            end
            S_WAIT: begin
                if (start_now)
                    state_d = S_READ;
            end
            S_READ: begin
                if (rd_done)
                    state_d = S_WRITE;
            end
            S_WRITE: begin
                if (unit_done) begin
                    if (rem_q == REM_W'(1))
                        state_d = S_FINISH;
                    else if (iter_q == REM_W'(1))
                        state_d = S_WAIT;
                    else
                        state_d = S_READ;
                end
            end
            S_FINISH: begin
                state_d = (ctrl_q[25] && start_q != START_NOW) ? S_WAIT : S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // registers, counts and latched modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q     <= '0;
            dst_q     <= '0;
            ctrl_q    <= '0;
            data_q    <= '0;
            rem_q     <= '0;
            iter_q    <= '0;
            in_prog_q <= 1'b0;
            word_q    <= 1'b0;
            smode_q   <= STEP_INC;
            dmode_q   <= STEP_INC;
            start_q   <= START_NOW;
        end else begin
            if (cfg_wr_en && cfg_wr_sel == SEL_SRC)
                src_q <= cfg_wr_data;
            if (cfg_wr_en && cfg_wr_sel == SEL_DST)
                dst_q <= cfg_wr_data;
            if (ctrl_wr)
                ctrl_q <= cfg_wr_data;
            else if (state_q == S_FINISH && !ctrl_q[25])
                ctrl_q[31] <= 1'b0;

            if (en_rise) begin
                smode_q   <= dec_src;
                dmode_q   <= dec_dst;
                word_q    <= dec_word;
                start_q   <= dec_start;
                in_prog_q <= 1'b0;
            end
            if (start_now) begin
                rem_q     <= rem_start;
                iter_q    <= iter_start;
                in_prog_q <= 1'b1;
            end else if (unit_done) begin
                rem_q  <= rem_q - REM_W'(1);
                iter_q <= iter_q - REM_W'(1);
            end
            if (state_q == S_FINISH)
                in_prog_q <= 1'b0;
            if (rd_done)
                data_q <= word_q ? mem_rdata : {16'h0000, mem_rdata[15:0]};
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == S_READ) || (state_q == S_WRITE);
        mem_we    = (state_q == S_WRITE);
        mem_addr  = (state_q == S_WRITE) ? dst_ptr : src_ptr;
        mem_wdata = (state_q == S_WRITE) ? data_q : 32'h0;
        cpu_stall = (state_q == S_READ) || (state_q == S_WRITE);
        irq       = (state_q == S_FINISH) && ctrl_q[30];
        ctrl_rd   = ctrl_q;
    end

    // dec_rep and dec_irq are read live from ctrl_q instead
    logic unused_dec;
    assign unused_dec = dec_rep ^ dec_irq ^ dst_next[0];

endmodule

// File: rtl/dma_channel_engine_chk.sv
module dma_channel_engine_chk #(
    parameter int CHUNK = 112
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [1:0]  cfg_wr_sel,
    input logic [31:0] ctrl_rd,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        mem_ready,
    input logic        cpu_stall,
    input logic        irq
);
    int   burst_writes;
    logic we_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_writes <= 0;
            we_d         <= 1'b0;
        end else begin
            we_d <= mem_we;
            if (!cpu_stall)
                burst_writes <= 0;
            else if (mem_we && !we_d)
                burst_writes <= burst_writes + 1;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we)); // R12

    AST_STALL_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> mem_req); // R11

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R10

    AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ctrl_rd[25] && !(cfg_wr_en && cfg_wr_sel == 2'd2) |=> !ctrl_rd[31]); // R10

    AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall && ctrl_rd[29:27] == 3'd7 |-> burst_writes <= CHUNK); // R8

endmodule

bind dma_channel_engine dma_channel_engine_chk #(.CHUNK(CHUNK)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_sel (cfg_wr_sel),
    .ctrl_rd    (ctrl_rd),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_ready  (mem_ready),
    .cpu_stall  (cpu_stall),
    .irq        (irq)
);

// File: tb/dma_channel_engine_tb_top.sv
module dma_channel_engine_tb_top;

    localparam int CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [31:0] cfg_wr_data = 32'h0;
    logic [31:0] ctrl_rd;
    logic [7:0]  trig_in = 8'h0;
    logic        mem_req, mem_we, mem_ready, cpu_stall, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0, errors = 0;
    int stall_cyc = 0, wr_cnt = 0, irq_cnt = 0, cyc = 0, tcnt = 0;
    bit throttle = 1'b0, done = 1'b0;
    string cur_tag = "R1";
    logic [63:0] exp_q[$];

    always #2 clk = ~clk;

    dma_channel_engine #(.CNT_W(CNT_W), .CHUNK(112), .TRIG_N(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .ctrl_rd(ctrl_rd), .trig_in(trig_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .cpu_stall(cpu_stall), .irq(irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a * 32'h9E3779B1 + 32'h1234_5678;
    endfunction

    assign mem_rdata = pat(mem_addr);
    assign mem_ready = throttle ? (tcnt % 3 != 0) : 1'b1;

    function automatic logic [31:0] mk_ctrl(input bit en, input bit ie, input logic [2:0] st,
                                            input bit word, input bit rep, input logic [1:0] sm,
                                            input logic [1:0] dm, input int cnt);
        return {en, ie, st, word, rep, sm, dm, 21'(cnt)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    bit          prev_wr = 1'b0;
    logic [31:0] prev_addr = 32'h0, prev_data = 32'h0;
    always @(negedge clk) begin
        logic [63:0] e;
        cyc++;
        tcnt++;
        if (prev_wr && !(mem_req && mem_we)) begin
            wr_cnt++;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected write actual=%0h expected=none", cur_tag, {prev_addr, prev_data});
            end else begin
                e = exp_q.pop_front();
                if (e != {prev_addr, prev_data}) begin
                    errors++;
                    $display("FAIL %s write actual=%0h expected=%0h", cur_tag, {prev_addr, prev_data}, e);
                end
            end
        end
        prev_wr   = mem_req && mem_we;
        prev_addr = mem_addr;
        prev_data = mem_wdata;
        if (cpu_stall) stall_cyc++;
        if (irq) irq_cnt++;
    end

    // watchdog
    always @(negedge clk) begin
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // driver: push expected writes
    task automatic push_units(inout logic [31:0] s, inout logic [31:0] d, input int sd,
                              input int dd, input bit word, input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] v;
            v = word ? pat(s) : {16'h0, pat(s)[15:0]};
            exp_q.push_back({d, v});
            s = s + 32'(sd);
            d = d + 32'(dd);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        trig_in[k] = 1'b1;
        @(negedge clk);
        trig_in[k] = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_end();
        while (!cpu_stall) @(negedge clk);
        while (cpu_stall) @(negedge clk);
        run(3);
    endtask

    initial begin
        logic [31:0] s, d;
        int b_st, b_wr, b_irq;

        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!cpu_stall && !irq && !mem_req && !mem_we, "R1 outputs idle", {cpu_stall, irq, mem_req, mem_we}, 0);
        check(ctrl_rd == 0, "R1 ctrl zero", ctrl_rd, 0);

        // T2: word, fixed source (R4), incrementing destination, immediate start (R7), irq (R10)
        cur_tag = "R4";
        s = 32'h0200_0000; d = 32'h0300_0100;
        push_units(s, d, 0, 4, 1'b1, 4);
        wr_reg(2'd0, 32'h0200_0000);
        wr_reg(2'd1, 32'h0300_0100);
        b_st = stall_cyc; b_irq = irq_cnt;
        wr_reg(2'd2, mk_ctrl(1, 1, 3'd0, 1, 0, 2'd2, 2'd0, 4));
        wait_end();
        check(stall_cyc - b_st == 12, "R9 word unit cost 2+1", stall_cyc - b_st, 12);
        check(irq_cnt - b_irq == 1, "R10 one irq pulse", irq_cnt - b_irq, 1);
        check(ctrl_rd[31] == 1'b0, "R10 enable cleared", ctrl_rd[31], 0);
        check(exp_q.size() == 0, "R7 immediate start moved all units", exp_q.size(), 0);

        // T3: halfword (R5), decrementing source, fixed destination, throttled ready (R12)
        cur_tag = "R5";
        throttle = 1'b1;
        s = 32'h0200_0010; d = 32'h0400_0000;
        push_units(s, d, -2, 0, 1'b0, 3);
        wr_reg(2'd0, 32'h0200_0010);
        wr_reg(2'd1, 32'h0400_0000);
        wr_reg(2'd2, mk_ctrl(1, 0, 3'd0, 0, 0, 2'd1, 2'd2, 3));
        wait_end();
        throttle = 1'b0;
        check(exp_q.size() == 0, "R12 all halfword units written", exp_q.size(), 0);

        // T4: cost table regions 8 and A, source code 3 increments (R4)
        cur_tag = "R9";
        s = 32'h0800_0000; d = 32'h0A00_0000;
        push_units(s, d, 4, 4, 1'b1, 2);
        wr_reg(2'd0, 32'h0800_0000);
        wr_reg(2'd1, 32'h0A00_0000);
        b_st = stall_cyc;
        wr_reg(2'd2, mk_ctrl(1, 0, 3'd0, 1, 0, 2'd3, 2'd0, 2));
        wait_end();
        check(stall_cyc - b_st == 44, "R9 regions 8+A word cost", stall_cyc - b_st, 44);
        check(exp_q.size() == 0, "R4 source code 3 increments", exp_q.size(), 0);

        // T5: zero count means 2^CNT_W units; destination decrement (R3)
        cur_tag = "R6";
        s = 32'h0300_0000; d = 32'h0600_1000;
        push_units(s, d, 2, -2, 1'b0, 256);
        wr_reg(2'd0, 32'h0300_0000);
        wr_reg(2'd1, 32'h0600_1000);
        b_st = stall_cyc; b_wr = wr_cnt;
        wr_reg(2'd2, mk_ctrl(1, 0, 3'd0, 0, 0, 2'd0, 2'd1, 0));
        wait_end();
        check(wr_cnt - b_wr == 256, "R6 zero count gives 256 units", wr_cnt - b_wr, 256);
        check(stall_cyc - b_st == 512, "R11 stall spans all units", stall_cyc - b_st, 512);
        check(exp_q.size() == 0, "R3 destination decrement", exp_q.size(), 0);

        // T6: FIFO mode, 200 units in bursts of 112 (R8)
        cur_tag = "R8";
        s = 32'h0200_1000; d = 32'h0400_0400;
        push_units(s, d, 4, 0, 1'b1, 200);
        wr_reg(2'd0, 32'h0200_1000);
        wr_reg(2'd1, 32'h0400_0400);
        b_st = stall_cyc; b_wr = wr_cnt; b_irq = irq_cnt;
        wr_reg(2'd2, mk_ctrl(1, 1, 3'd7, 1, 0, 2'd0, 2'd2, 200));
        run(10);
        check(!cpu_stall && wr_cnt == b_wr, "R7 no start without trigger", wr_cnt - b_wr, 0);
        pulse(7);
        run(30);
        pulse(7); // R7 ignored while moving
        while (!(mem_we && wr_cnt - b_wr == 111)) @(negedge clk);
        trig_in[7] = 1'b1; // coincides with final write of the burst
        @(negedge clk);
        trig_in[7] = 1'b0;
        run(20);
        check(!cpu_stall, "R8 parked after burst", cpu_stall, 0);
        check(wr_cnt - b_wr == 112, "R8 burst cap 112", wr_cnt - b_wr, 112);
        check(stall_cyc - b_st == 336, "R11 stall for one burst", stall_cyc - b_st, 336);
        check(ctrl_rd[31] && irq_cnt == b_irq, "R8 enable kept, no irq", {ctrl_rd[31], 32'(irq_cnt - b_irq)}, 64'h1_0000_0000);
        pulse(7);
        wait_end();
        check(wr_cnt - b_wr == 200, "R8 resume finishes count", wr_cnt - b_wr, 200);
        check(irq_cnt - b_irq == 1 && !ctrl_rd[31], "R10 completion after last burst", {ctrl_rd[31], 32'(irq_cnt - b_irq)}, 1);
        check(exp_q.size() == 0, "R8 pointers persisted", exp_q.size(), 0);

        // T8: trigger 1, repeat, destination reload (R3), enable rewrite ignored (R2)
        cur_tag = "R3";
        s = 32'h0200_2000; d = 32'h0300_3000;
        push_units(s, d, 4, 4, 1'b1, 2);
        wr_reg(2'd0, 32'h0200_2000);
        wr_reg(2'd1, 32'h0300_3000);
        b_irq = irq_cnt;
        wr_reg(2'd2, mk_ctrl(1, 0, 3'd1, 1, 1, 2'd0, 2'd3, 2));
        pulse(1);
        wait_end();
        check(ctrl_rd[31] == 1'b1, "R10 repeat keeps enable", ctrl_rd[31], 1);
        check(irq_cnt == b_irq, "R10 no irq when bit 30 clear", irq_cnt - b_irq, 0);
        cur_tag = "R2";
        wr_reg(2'd0, 32'h0200_9000);
        wr_reg(2'd2, mk_ctrl(1, 0, 3'd1, 1, 1, 2'd0, 2'd3, 2));
        d = 32'h0300_3000;
        push_units(s, d, 4, 4, 1'b1, 2);
        pulse(1);
        wait_end();
        check(exp_q.size() == 0, "R2 R3 working source kept, destination reloaded", exp_q.size(), 0);
        wr_reg(2'd2, 32'h0);
        run(5);
        check(!cpu_stall && !mem_req, "R11 idle at end", {cpu_stall, mem_req}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule